// File: doc/BRIEF.md
# Pin-Driven Sleep Freeze Controller

This block sits between a device's pads and its internal logic and implements a hold mode driven from one dedicated sleep pin. While the sleep pin is sampled high, every pad output value and output enable is held at the level it had on entry. Pads that were tri-stated stay tri-stated. The pin levels seen by the core are held by keeper registers, so later pad activity cannot reach the core. The core's clock enable is forced low, so all core register state stays where it was.

When the sleep pin is released, a wake-up window of `WAKE_CYC` cycles of a free-running reference clock must run before anything is treated as valid again. A status output `awake` rises only when this window has fully elapsed. If the sleep pin rises again during the window, the count starts over. A parameter `PD_EN` turns the feature on or off. With the feature off, the sleep pin is an ordinary logic input and is passed to the core unchanged.

Top module: `pd_freeze`

## Requirements
- R1: After reset, `awake` is 1. The pads and the core see live values: `pad_out`=`core_out`, `pad_oe`=`core_oe`, `in_to_core`=`pin_in`.
- R2: With `PD_EN`=1, a rising clock edge that samples `sleep_pin`=1 while `awake`=1 drops `awake` to 0 right after that edge.
- R3: While `awake`=0, `pad_out` keeps the `core_out` value sampled at the entry edge, whatever `core_out` does.
- R4: While `awake`=0, `pad_oe` keeps the `core_oe` value sampled at the entry edge. A pad whose enable was 0 (high-impedance) at entry stays 0.
- R5: While `awake`=0, `in_to_core` keeps the `pin_in` value sampled at the entry edge, and later changes on `pin_in` have no effect on it.
- R6: `core_clk_en` equals `clk_req` while `awake`=1 and is 0 while `awake`=0.
- R7: With `PD_EN`=1, `pd_as_input` is always 0, so the sleep pin never reaches the core as data.
- R8: The first edge that samples `sleep_pin`=0 while asleep starts the wake-up window. `awake` stays 0 for that edge and the following `WAKE_CYC`-1 edges, then rises at the next edge. The held values stay in place for the whole window.
- R9: An edge that samples `sleep_pin`=1 during the wake-up window discards the partial count. A later release needs the full `WAKE_CYC` cycles again.
- R10: With `PD_EN`=0, `pd_as_input` follows `sleep_pin`, `awake` stays 1 and no value is ever held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_pin | input | 1 | Dedicated sleep pin |
| pin_in | input | N_IN | Raw pad input levels |
| clk_req | input | 1 | Core clock enable request |
| core_out | input | N_OUT | Output data from core logic |
| core_oe | input | N_OUT | Output-enable terms from core logic |
| in_to_core | output | N_IN | Pad levels delivered to the core (held while asleep) |
| core_clk_en | output | 1 | Gated clock enable to the core |
| pad_out | output | N_OUT | Data driven to the pads |
| pad_oe | output | N_OUT | Enables driven to the pads |
| pd_as_input | output | 1 | Sleep pin as a logic input (only when the feature is off) |
| awake | output | 1 | High when inputs and outputs are valid |

## Verification
The bench changes core outputs, enables and pad inputs after entry. A design that kept tracking any of them would show the new values on the pads or at the core. It mixes tri-stated and driven pads so that a design that re-enabled a high-impedance pad is caught. It counts the wake-up window edge by edge, which exposes an off-by-one in the counter. It also pulses the sleep pin inside the window to catch a counter that resumes instead of restarting. A second instance with the feature off checks that the pin passes through and that nothing freezes.

// File: rtl/pd_freeze.sv
module pd_freeze #(
  parameter int N_IN     = 4,
  parameter int N_OUT    = 4,
  parameter int WAKE_CYC = 5,
  parameter bit PD_EN    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_pin,
  input  logic [N_IN-1:0]  pin_in,
  input  logic             clk_req,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_IN-1:0]  in_to_core,
  output logic             core_clk_en,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic             pd_as_input,
  output logic             awake
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  typedef enum logic [1:0] {RUN, DOWN, WAKE} st_t;
  st_t st;
  logic [CW-1:0]    cnt;
  logic [N_IN-1:0]  in_hold;
  logic [N_OUT-1:0] out_hold, oe_hold;

  wire frozen = (st != RUN);

  generate
    if (PD_EN) begin : g_on
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st  <= RUN;
          cnt <= '0;
        end else begin
          case (st)
            RUN:  if (sleep_pin) st <= DOWN;
            DOWN: if (!sleep_pin) begin st <= WAKE; cnt <= '0; end
            WAKE: begin
              if (sleep_pin) begin
                st  <= DOWN;
                cnt <= '0;
              end else if (cnt == CW'(WAKE_CYC - 1)) begin
                st <= RUN;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: st <= RUN;
          endcase
        end
      end
      assign pd_as_input = 1'b0;
    end else begin : g_off
      assign st  = RUN;
      assign cnt = '0;
      assign pd_as_input = sleep_pin;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hold  <= '0;
      out_hold <= '0;
      oe_hold  <= '0;
    end else if (!frozen) begin
      in_hold  <= pin_in;
      out_hold <= core_out;
      oe_hold  <= core_oe;
    end
  end

  assign in_to_core  = frozen ? in_hold  : pin_in;
  assign pad_out     = frozen ? out_hold : core_out;
  assign pad_oe      = frozen ? oe_hold  : core_oe;
  assign core_clk_en = clk_req & ~frozen;
  assign awake       = ~frozen;
endmodule

// File: rtl/pd_freeze_chk.sv
module pd_freeze_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter bit PD_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_pin,
  input logic             clk_req,
  input logic [N_IN-1:0]  in_to_core,
  input logic             core_clk_en,
  input logic [N_OUT-1:0] pad_out,
  input logic [N_OUT-1:0] pad_oe,
  input logic             pd_as_input,
  input logic             awake
);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (PD_EN && awake && sleep_pin) |=> !awake);
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && $past(!awake)) |-> $stable(pad_out));
  p_oe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && $past(!awake)) |-> $stable(pad_oe));
  p_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && $past(!awake)) |-> $stable(in_to_core));
  p_clk_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> !core_clk_en);
  p_pin_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    PD_EN |-> !pd_as_input);
  p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && $past(!awake)) |-> $past(!sleep_pin));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && sleep_pin) |=> !awake);
  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !PD_EN |-> (awake && pd_as_input == sleep_pin));
endmodule

bind pd_freeze pd_freeze_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .PD_EN(PD_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .clk_req(clk_req),
  .in_to_core(in_to_core), .core_clk_en(core_clk_en), .pad_out(pad_out),
  .pad_oe(pad_oe), .pd_as_input(pd_as_input), .awake(awake));

// File: tb/sim_pd_freeze.sv
module sim_pd_freeze;
  localparam int NI = 4, NO = 4, W = 5;
  logic clk = 0, rst_n = 0;
  logic sleep_pin = 0, clk_req = 1;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0, core_oe = '0;
  logic [NI-1:0] in_to_core, in_b;
  logic [NO-1:0] pad_out, pad_oe, pad_out_b, pad_oe_b;
  logic cke, pdin, awake, cke_b, pdin_b, awake_b;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pd_freeze #(.N_IN(NI), .N_OUT(NO), .WAKE_CYC(W), .PD_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .pin_in(pin_in),
    .clk_req(clk_req), .core_out(core_out), .core_oe(core_oe),
    .in_to_core(in_to_core), .core_clk_en(cke), .pad_out(pad_out),
    .pad_oe(pad_oe), .pd_as_input(pdin), .awake(awake));

  pd_freeze #(.N_IN(NI), .N_OUT(NO), .WAKE_CYC(W), .PD_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .pin_in(pin_in),
    .clk_req(clk_req), .core_out(core_out), .core_oe(core_oe),
    .in_to_core(in_b), .core_clk_en(cke_b), .pad_out(pad_out_b),
    .pad_oe(pad_oe_b), .pd_as_input(pdin_b), .awake(awake_b));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    check("R1 awake", awake, 1);
    check("R1 pad_out", pad_out, core_out);
    check("R1 pad_oe", pad_oe, core_oe);
    check("R1 in_to_core", in_to_core, pin_in);
  endtask

  task automatic t_enter(input logic [3:0] d, input logic [3:0] oe, input logic [3:0] p);
    core_out = d; core_oe = oe; pin_in = p; sleep_pin = 1;
    @(negedge clk);
    check("R2 awake low", awake, 0);
    check("R7 pd_as_input", pdin, 0);
    core_out = ~d; core_oe = ~oe; pin_in = ~p; clk_req = 1;
    repeat (3) @(negedge clk);
    check("R3 pad_out held", pad_out, d);
    check("R4 pad_oe held", pad_oe, oe);
    check("R4 hi-z kept", (~oe) & pad_oe, 0);
    check("R5 in_to_core held", in_to_core, p);
    check("R6 clk gated", cke, 0);
  endtask

  task automatic t_wake(input logic [3:0] d);
    sleep_pin = 0;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      check("R8 still asleep", awake, 0);
      check("R8 outputs held", pad_out, d);
    end
    @(negedge clk);
    check("R8 awake", awake, 1);
    check("R8 live out", pad_out, core_out);
    check("R6 clk passes", cke, clk_req);
    check("R5 live in", in_to_core, pin_in);
  endtask

  task automatic t_restart(input logic [3:0] d);
    sleep_pin = 0;
    repeat (3) @(negedge clk);
    check("R9 mid window", awake, 0);
    sleep_pin = 1;
    @(negedge clk);
    check("R9 back down", awake, 0);
    t_wake(d);
  endtask

  task automatic t_off();
    sleep_pin = 1; core_out = 4'h9; pin_in = 4'h6;
    @(negedge clk);
    check("R10 passthru", pdin_b, 1);
    check("R10 awake", awake_b, 1);
    core_out = 4'h3;
    #1;
    check("R10 no freeze", pad_out_b, 4'h3);
    sleep_pin = 0;
    #1;
    check("R10 passthru low", pdin_b, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        core_out = 4'hA; core_oe = 4'h5; pin_in = 4'h3;
        #1;
        t_reset();
        @(negedge clk);
        t_enter(4'hA, 4'h5, 4'h3);
        t_wake(4'hA);
        @(negedge clk);
        t_enter(4'h6, 4'hC, 4'h9);
        t_restart(4'h6);
        @(negedge clk);
        t_off();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule